// File: doc/BRIEF.md
# Complementary PWM Output Stage with Dead-Time and Break

This block turns a free-running time-base count into a pair of gate-drive signals for one half-bridge leg. A count below the compare value makes an internal reference active, so the duty cycle follows the compare value within each period. The block drives a main pin that follows the reference and a complementary pin that follows its inverse. It holds both pins inactive for a programmable number of clock cycles at every transition, so the two switches of a leg are never on together.

Each pin has its own polarity bit and its own idle level. An enable flag gates both pins. When the flag is clear, the pins drive their idle levels. A break input forces both pins to their idle levels at once, with no clock edge needed. The break also clears the enable flag, so the stage stays quiet after the break is released. Software restarts it with a set pulse. The counter that produces the count value lives outside the block.

Top module: `cpwm_deadband`

## Requirements
- R1: The reference is active while `cnt_i < cmp_i` and inactive from the cycle the count reaches `cmp_i` until the count wraps to zero. The reference is sampled on each rising clock edge.
- R2: With a dead-time of zero, the complementary output is the exact inverse of the main output in every cycle.
- R3: With dead-time D, a reference edge sampled at clock edge k makes the newly active output active only after edge k+D. The output that was active goes inactive after edge k.
- R4: While the stage is enabled and no break is present, the main and complementary outputs are never active in the same cycle.
- R5: A reference pulse, active or inactive, that lasts no more than D cycles never activates the output it would have turned on.
- R6: Each pin equals its active state XOR its polarity bit. A polarity bit of 1 means the pin is active-low.
- R7: While the enable flag is clear, `out_main_o` equals `idle_main_i` and `out_comp_o` equals `idle_comp_i`. Reset clears the enable flag.
- R8: While `brk_i` is high, both pins show their idle levels without waiting for a clock edge.
- R9: A break clears the enable flag asynchronously. While `brk_i` is high, `oe_set_i` is ignored. After release, the flag stays clear until `oe_set_i` is sampled high at a clock edge.
- R10: A compare value of 0 keeps the main output inactive for the whole period. A compare value above `period_i` keeps the main output active for the whole period.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cnt_i | input | CW | Current time-base count |
| period_i | input | CW | Last count value of the period |
| cmp_i | input | CW | Compare value |
| dead_i | input | DTW | Dead-time in clock cycles |
| pol_main_i | input | 1 | Main pin polarity (1 = active-low) |
| pol_comp_i | input | 1 | Complementary pin polarity (1 = active-low) |
| idle_main_i | input | 1 | Main pin level when disabled or in break |
| idle_comp_i | input | 1 | Complementary pin level when disabled or in break |
| brk_i | input | 1 | Asynchronous break request, active high |
| oe_set_i | input | 1 | Sets the enable flag at a clock edge |
| oe_o | output | 1 | Enable flag |
| out_main_o | output | 1 | Main gate output |
| out_comp_o | output | 1 | Complementary gate output |

## Verification
Latency differs by stimulus, and each check is placed accordingly:

- **Reference path:** a count sampled at clock edge k affects the pins right after edge k when D is zero. With dead-time D, the newly active output turns on after edge k+D.
- **Enable set:** an enable pulse shows on `oe_o` and the pins after the next edge.
- **Break:** a break affects the pins combinationally, within the same time step.

The bench drives every input 1 ns after a rising edge and samples the pins at that same point after the next edge. Expected values come from a sliding window over the sampled reference history: an output must be active only when the last D+1 samples all agree. The break case is checked 1 ns after `brk_i` rises, with no clock edge in between.

// File: rtl/cpwm_deadband.sv
module cpwm_deadband #(
  parameter int CW  = 16,
  parameter int DTW = 8
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic [CW-1:0]  cnt_i,
  input  logic [CW-1:0]  period_i,
  input  logic [CW-1:0]  cmp_i,
  input  logic [DTW-1:0] dead_i,
  input  logic           pol_main_i,
  input  logic           pol_comp_i,
  input  logic           idle_main_i,
  input  logic           idle_comp_i,
  input  logic           brk_i,
  input  logic           oe_set_i,
  output logic           oe_o,
  output logic           out_main_o,
  output logic           out_comp_o
);

  logic           ref_raw;
  logic           ref_q;
  logic [DTW-1:0] gap_q;
  logic           settled;
  logic           main_act;
  logic           comp_act;
  logic           oe_q;
  logic           drive;

  assign ref_raw = (cmp_i > period_i) || (cnt_i < cmp_i);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ref_q <= 1'b0;
      gap_q <= '0;
    end else if (ref_raw != ref_q) begin
      ref_q <= ref_raw;
      gap_q <= dead_i;
    end else if (gap_q != '0) begin
      gap_q <= gap_q - 1'b1;
    end
  end

  assign settled  = (gap_q == '0);
  assign main_act = ref_q & settled;
  assign comp_act = ~ref_q & settled;

  always_ff @(posedge clk or negedge rst_n or posedge brk_i) begin
    if (!rst_n)        oe_q <= 1'b0;
    else if (brk_i)    oe_q <= 1'b0;
    else if (oe_set_i) oe_q <= 1'b1;
  end

  assign oe_o       = oe_q;
  assign drive      = oe_q & ~brk_i;
  assign out_main_o = drive ? (main_act ^ pol_main_i) : idle_main_i;
  assign out_comp_o = drive ? (comp_act ^ pol_comp_i) : idle_comp_i;

endmodule

module cpwm_deadband_chk #(
  parameter int DTW = 8
) (
  input logic           clk,
  input logic           rst_n,
  input logic [DTW-1:0] dead_i,
  input logic           pol_main_i,
  input logic           pol_comp_i,
  input logic           idle_main_i,
  input logic           idle_comp_i,
  input logic           brk_i,
  input logic           oe_o,
  input logic           out_main_o,
  input logic           out_comp_o
);

  a_r4_no_overlap: assert property (@(posedge clk) disable iff (!rst_n)
    (oe_o && !brk_i) |-> !((out_main_o ^ pol_main_i) && (out_comp_o ^ pol_comp_i)));

  a_r8_break_idle: assert property (@(posedge clk) disable iff (!rst_n)
    brk_i |-> (out_main_o == idle_main_i) && (out_comp_o == idle_comp_i));

  a_r9_break_clears_enable: assert property (@(posedge clk) disable iff (!rst_n)
    brk_i |-> !oe_o);

  a_r7_disabled_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !oe_o |-> (out_main_o == idle_main_i) && (out_comp_o == idle_comp_i));

  a_r3_gap_before_main: assert property (@(posedge clk) disable iff (!rst_n)
    ((dead_i != '0) && oe_o && $past(oe_o) && !brk_i && !$past(brk_i)
      && $stable(pol_main_i) && $stable(pol_comp_i)
      && $rose(out_main_o ^ pol_main_i))
    |-> !$past(out_comp_o ^ pol_comp_i));

endmodule

bind cpwm_deadband cpwm_deadband_chk #(.DTW(DTW)) u_chk (
  .clk(clk), .rst_n(rst_n), .dead_i(dead_i),
  .pol_main_i(pol_main_i), .pol_comp_i(pol_comp_i),
  .idle_main_i(idle_main_i), .idle_comp_i(idle_comp_i),
  .brk_i(brk_i), .oe_o(oe_o),
  .out_main_o(out_main_o), .out_comp_o(out_comp_o)
);

// File: tb/tb_cpwm_deadband.sv
`timescale 1ns/100ps
module tb_cpwm_deadband;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] cnt = '0, period = 16'd9, cmp = 16'd4;
  logic [7:0]  dead = '0;
  logic        pol_m = 0, pol_c = 0, idle_m = 0, idle_c = 0;
  logic        brk = 0, oe_set = 0;
  logic        oe_o, out_m, out_c;

  int   checks = 0, fails = 0;
  bit   done = 0;
  logic [63:0] hist = '0;
  logic oe_exp = 0;

  always #2.5 clk = ~clk;

  cpwm_deadband dut (
    .clk(clk), .rst_n(rst_n), .cnt_i(cnt), .period_i(period), .cmp_i(cmp),
    .dead_i(dead), .pol_main_i(pol_m), .pol_comp_i(pol_c),
    .idle_main_i(idle_m), .idle_comp_i(idle_c), .brk_i(brk),
    .oe_set_i(oe_set), .oe_o(oe_o), .out_main_o(out_m), .out_comp_o(out_c)
  );

  task automatic chk(input string tag, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s t=%0t actual=%b expected=%b", tag, $time, act, exp);
    end
  endtask

  task automatic check_pins(input string tag);
    logic [63:0] mask;
    logic ma, ca, em, ec;
    mask = (64'd1 << (dead + 1)) - 64'd1;
    ma = ((hist & mask) == mask);
    ca = ((hist & mask) == 64'd0);
    em = (oe_exp && !brk) ? (ma ^ pol_m) : idle_m;
    ec = (oe_exp && !brk) ? (ca ^ pol_c) : idle_c;
    chk({tag, " main"}, out_m, em);
    chk({tag, " comp"}, out_c, ec);
    chk({tag, " oe"}, oe_o, oe_exp);
  endtask

  task automatic step(input string tag);
    logic refb, oe_nx;
    refb  = (cmp > period) || (cnt < cmp);
    hist  = {hist[62:0], refb};
    oe_nx = brk ? 1'b0 : (oe_set ? 1'b1 : oe_exp);
    @(posedge clk); #1;
    oe_exp = oe_nx;
    oe_set = 0;
    check_pins(tag);
    cnt = (cnt >= period) ? 16'd0 : cnt + 16'd1;
  endtask

  task automatic run(input int n, input string tag);
    for (int i = 0; i < n; i++) step(tag);
  endtask

  task automatic do_reset();
    rst_n = 0; brk = 0; oe_set = 0; cnt = '0; hist = '0; oe_exp = 0;
    @(posedge clk); @(posedge clk); #1;
    rst_n = 1;
  endtask

  task automatic enable_run(input int n, input string tag);
    oe_set = 1;
    run(n, tag);
  endtask

  // R7: reset state
  task automatic t_reset();
    idle_m = 1; idle_c = 0; rst_n = 0;
    @(posedge clk); #1;
    chk("R7 reset oe", oe_o, 1'b0);
    chk("R7 reset main idle", out_m, 1'b1);
    chk("R7 reset comp idle", out_c, 1'b0);
  endtask

  // R1 R2: zero dead-time, plain inverse
  task automatic t_basic();
    do_reset(); period = 9; cmp = 4; dead = 0; pol_m = 0; pol_c = 0;
    enable_run(30, "R1 R2");
  endtask

  // R3 R4: dead-band insertion
  task automatic t_dead();
    do_reset(); period = 11; cmp = 5; dead = 3;
    enable_run(40, "R3 R4");
  endtask

  // R5: pulse shorter than dead-time suppressed
  task automatic t_short();
    int seen;
    do_reset(); period = 9; cmp = 2; dead = 4; seen = 0;
    oe_set = 1;
    for (int i = 0; i < 30; i++) begin
      step("R5");
      if (out_m) seen++;
    end
    chk("R5 main never active", seen == 0, 1'b1);
  endtask

  // R6: polarity
  task automatic t_pol();
    do_reset(); period = 9; cmp = 5; dead = 2; pol_m = 1; pol_c = 1;
    enable_run(30, "R6");
    pol_m = 0; pol_c = 0;
  endtask

  // R7: disabled drives idle levels
  task automatic t_idle();
    do_reset(); idle_m = 1; idle_c = 1; dead = 1;
    run(15, "R7 disabled");
    idle_m = 0; idle_c = 1;
    run(10, "R7 disabled");
    idle_m = 0; idle_c = 0;
  endtask

  // R8 R9: break
  task automatic t_break();
    do_reset(); period = 9; cmp = 5; dead = 1; idle_m = 0; idle_c = 1;
    enable_run(12, "R8 pre");
    brk = 1; #1;
    oe_exp = 0;
    chk("R8 async main idle", out_m, idle_m);
    chk("R8 async comp idle", out_c, idle_c);
    chk("R9 oe cleared", oe_o, 1'b0);
    oe_set = 1;
    run(3, "R9 set ignored in break");
    brk = 0;
    run(6, "R9 stays off");
    enable_run(20, "R9 resume");
    chk("R9 resumed", oe_o, 1'b1);
  endtask

  // R10: duty extremes
  task automatic t_extreme();
    do_reset(); period = 9; cmp = 0; dead = 2;
    enable_run(25, "R10 zero");
    cmp = 20;
    run(25, "R10 full");
  endtask

  initial begin
    t_reset();
    t_basic();
    t_dead();
    t_short();
    t_pol();
    t_idle();
    t_break();
    t_extreme();
    if (!done) begin
      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    #(200000 * 5);
    if (!done) begin
      done = 1;
      checks++; fails++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule